// File: doc/BRIEF.md
# Ring-Oscillator Supply Droop Monitor

The monitor watches one supply rail through a ring oscillator that runs on that rail. When the rail sags, the oscillator slows down, so fewer oscillator cycles fit into a fixed time window. A free-running Gray-coded counter in the oscillator domain is carried into the 200 MHz reference domain through a two-flop synchronizer. At every sample-window tick, the monitor takes the difference from the previous snapshot, which gives the number of oscillator cycles in the window that just ended. It then compares that count with an absolute threshold.

A single low window does not raise the alarm. The alarm pulses for one reference cycle, right after a tick, only once a configurable number of back-to-back windows have all come in below the threshold. A saturating event counter records every alarm for telemetry. If the threshold input is zero, a built-in default of 2048 is used instead, so an uncalibrated part still has a working trip point.

Top module: `droop_monitor`

## Requirements
- R1: While rst_ni is low, alarm_o is 0 and event_count_o is 0.
- R2: The window count is exactly the number of oscillator rising edges between two consecutive ticks. With a steady oscillator giving 160 edges per window, a threshold of 100 produces no alarm.
- R3: A window count equal to the threshold is not below it and clears the run of low windows. A count of exactly 160 against a threshold of 160 never alarms.
- R4: An alarm fires only on the tick that completes CONFIRM consecutive below-threshold windows (default 2). After a single low window, no alarm has fired.
- R5: A window that is not below the threshold clears the run. The pattern low, not low, low gives no alarm, and one further low window gives one alarm.
- R6: After an alarm the run restarts from zero. A droop that persists gives exactly one alarm per CONFIRM windows.
- R7: alarm_o is high for exactly one reference cycle, namely the cycle right after a reference edge at which tick_i was high.
- R8: A threshold input of zero selects the default threshold DEF_THRESH (2048).
- R9: event_count_o increases by one for each alarm, at the same edge that raises alarm_o, and changes at no other time.
- R10: event_count_o saturates at its all-ones value and does not wrap.
- R11: The first tick after reset only takes a snapshot and does no comparison. With every window below the threshold, the first alarm comes on the third tick after reset.
- R12: A slower oscillator gives a lower window count. Halving the oscillator frequency (80 edges per window) against a threshold of 100 alarms once every CONFIRM windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference sample clock, 200 MHz |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| ro_clk_i | input | 1 | Ring-oscillator clock from the monitored rail |
| tick_i | input | 1 | One-cycle pulse in the clk_i domain marking the end of a sample window |
| thresh_i | input | CNT_W (16) | Absolute oscillator-cycles-per-window threshold; 0 selects DEF_THRESH |
| alarm_o | output | 1 | One-cycle droop alarm, in the cycle after the qualifying tick |
| event_count_o | output | EVT_W (32) | Saturating count of alarms |

## Verification
The bench clocks the oscillator at exact fractions of the reference period, so every window holds exactly 160 or 80 edges. This lets it probe the boundary at thresholds of 160 and 161. A design that counts edges wrongly across the clock crossing, or that compares with less-than-or-equal, alarms at 160 or stays quiet at 161. Further scenarios break a low run with one normal window, hold a droop over several windows, and check the third-tick timing after reset. These catch a run counter that is not cleared, one that does not restart after firing, and a first comparison made against a partial window. A second instance with a 3-bit event counter is driven past its limit, which exposes a counter that wraps. Zero is programmed as the threshold to show that it selects the default and is not taken as a literal trip point of zero.

// File: rtl/droop_pkg.sv
`timescale 1ns/1ps
package droop_pkg;
  localparam int unsigned CNT_W_DEF   = 16;
  localparam int unsigned THRESH_DEF  = 2048;
  localparam int unsigned CONFIRM_DEF = 2;
  localparam int unsigned EVT_W_DEF   = 32;

  typedef struct packed {
    logic valid;  // a comparison was made this cycle
    logic below;  // window count under effective threshold
  } sample_t;
endpackage

// File: rtl/droop_ro_counter.sv
`timescale 1ns/1ps
module droop_ro_counter #(
  parameter int unsigned W = 16
) (
  input  logic         ro_clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] gray_o
);
  logic [1:0]   rst_sync_q;
  logic         ro_rst_n;
  logic [W-1:0] bin_q, bin_nxt, gray_q;

  // reset asserts asynchronously, releases on the oscillator clock
  always_ff @(posedge ro_clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign ro_rst_n = rst_sync_q[1];

  assign bin_nxt = bin_q + W'(1);

  always_ff @(posedge ro_clk_i or negedge ro_rst_n) begin
    if (!ro_rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  assign gray_o = gray_q;
endmodule

// File: rtl/droop_gray_sync.sv
`timescale 1ns/1ps
module droop_gray_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= gray_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  logic [W-1:0] g;
  assign g = stage_q[STAGES-1];

  always_comb begin
    bin_o[W-1] = g[W-1];
    for (int i = int'(W) - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ g[i];
  end
endmodule

// File: rtl/droop_window_cmp.sv
`timescale 1ns/1ps
module droop_window_cmp
  import droop_pkg::*;
#(
  parameter int unsigned W          = 16,
  parameter int unsigned DEF_THRESH = 2048
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_bin_i,
  input  logic [W-1:0] thresh_i,
  output sample_t      sample_o,
  output logic         primed_o
);
  logic [W-1:0] prev_q, window, eff_thresh;
  logic         primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (tick_i) begin
      prev_q   <= cnt_bin_i;
      primed_q <= 1'b1;
    end
  end

  // modular difference: valid while a window holds fewer than 2**W edges
  assign window     = cnt_bin_i - prev_q;
  assign eff_thresh = (thresh_i == '0) ? W'(DEF_THRESH) : thresh_i;

  assign sample_o.valid = tick_i & primed_q;
  assign sample_o.below = window < eff_thresh;
  assign primed_o       = primed_q;
endmodule

// File: rtl/droop_qualifier.sv
`timescale 1ns/1ps
module droop_qualifier
  import droop_pkg::*;
#(
  parameter int unsigned CONFIRM = 2,
  localparam int unsigned STK_W  = (CONFIRM > 1) ? $clog2(CONFIRM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sample_t          sample_i,
  output logic             fire_o,
  output logic             alarm_o,
  output logic [STK_W-1:0] streak_o
);
  logic [STK_W-1:0] streak_q;
  logic             alarm_q;

  assign fire_o = sample_i.valid & sample_i.below & (streak_q == STK_W'(CONFIRM - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      streak_q <= '0;
      alarm_q  <= 1'b0;
    end else begin
      alarm_q <= fire_o;
      if (sample_i.valid) begin
        if (!sample_i.below || fire_o) streak_q <= '0;
        else                           streak_q <= streak_q + STK_W'(1);
      end
    end
  end

  assign alarm_o  = alarm_q;
  assign streak_o = streak_q;
endmodule

// File: rtl/droop_evt_counter.sv
`timescale 1ns/1ps
module droop_evt_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       count_q <= '0;
    else if (inc_i && (count_q != '1)) count_q <= count_q + W'(1);
  end

  assign count_o = count_q;
endmodule

// File: rtl/droop_monitor.sv
`timescale 1ns/1ps
module droop_monitor
  import droop_pkg::*;
#(
  parameter int unsigned CNT_W       = CNT_W_DEF,
  parameter int unsigned CONFIRM     = CONFIRM_DEF,
  parameter int unsigned DEF_THRESH  = THRESH_DEF,
  parameter int unsigned EVT_W       = EVT_W_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ro_clk_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             alarm_o,
  output logic [EVT_W-1:0] event_count_o
);
  localparam int unsigned STK_W = (CONFIRM > 1) ? $clog2(CONFIRM) : 1;

  logic [CNT_W-1:0] ro_gray, cnt_bin;
  sample_t          sample;
  logic             primed, fire;
  logic [STK_W-1:0] streak;

  droop_ro_counter #(.W(CNT_W)) u_ro_cnt (
    .ro_clk_i (ro_clk_i),
    .rst_ni   (rst_ni),
    .gray_o   (ro_gray)
  );

  droop_gray_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gray_i (ro_gray),
    .bin_o  (cnt_bin)
  );

  droop_window_cmp #(.W(CNT_W), .DEF_THRESH(DEF_THRESH)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .cnt_bin_i (cnt_bin),
    .thresh_i  (thresh_i),
    .sample_o  (sample),
    .primed_o  (primed)
  );

  droop_qualifier #(.CONFIRM(CONFIRM)) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .fire_o   (fire),
    .alarm_o  (alarm_o),
    .streak_o (streak)
  );

  droop_evt_counter #(.W(EVT_W)) u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (fire),
    .count_o (event_count_o)
  );
endmodule

// File: rtl/droop_monitor_chk.sv
`timescale 1ns/1ps
module droop_monitor_chk #(
  parameter int unsigned CONFIRM = 2,
  parameter int unsigned EVT_W   = 32,
  parameter int unsigned STK_W   = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             alarm_o,
  input logic [EVT_W-1:0] event_count_o,
  input logic             primed_i,
  input logic [STK_W-1:0] streak_i
);
  p_alarm_after_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> $past(tick_i));

  p_alarm_needs_prime_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> $past(primed_i));

  p_streak_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(streak_i) < int'(CONFIRM));

  p_evt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_count_o != $past(event_count_o)) |->
      (alarm_o && (event_count_o == $past(event_count_o) + EVT_W'(1))));

  p_evt_sat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(event_count_o) == {EVT_W{1'b1}}) |-> (event_count_o == {EVT_W{1'b1}}));
endmodule

bind droop_monitor droop_monitor_chk #(
  .CONFIRM (CONFIRM),
  .EVT_W   (EVT_W),
  .STK_W   (STK_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .alarm_o       (alarm_o),
  .event_count_o (event_count_o),
  .primed_i      (primed),
  .streak_i      (streak)
);

// File: tb/droop_monitor_tb.sv
`timescale 1ns/1ps
module droop_monitor_tb;
  localparam int unsigned TICK_DIV = 16;  // 160 edges per window at 0.5 ns

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ro_clk = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] thresh = 16'd4000;
  logic        alarm, alarm_sat;
  logic [31:0] evt;
  logic [2:0]  evt_sat;
  realtime     ro_half = 0.25;

  int checks = 0, fails = 0;
  int alarms_seen = 0, bad_align = 0, bad_width = 0;
  int exp_events = 0;
  bit prev_alarm = 1'b0;

  droop_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ro_clk_i(ro_clk), .tick_i(tick),
    .thresh_i(thresh), .alarm_o(alarm), .event_count_o(evt)
  );

  droop_monitor #(.EVT_W(3)) u_dut_sat (
    .clk_i(clk), .rst_ni(rst_n), .ro_clk_i(ro_clk), .tick_i(tick),
    .thresh_i(thresh), .alarm_o(alarm_sat), .event_count_o(evt_sat)
  );

  always #2.5 clk = ~clk;

  initial begin
    #0.1;
    forever #(ro_half) ro_clk = ~ro_clk;
  end

  initial begin
    int unsigned cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      tick = (cyc % TICK_DIV == 0);
    end
  end

  // alarm monitor: tick sampled at the edge, alarm just after it
  always @(posedge clk) begin
    bit tk;
    tk = tick;
    #1;
    if (alarm) begin
      alarms_seen++;
      if (!tk) bad_align++;
      if (prev_alarm) bad_width++;
    end
    prev_alarm = alarm;
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    repeat (n) @(posedge clk iff tick);
    @(negedge clk);
    #1;
  endtask

  task automatic settle();
    thresh = 16'd1;
    wait_ticks(2);
    alarms_seen = 0;
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check("R1 alarm in reset", alarm, 0);
    check("R1 events in reset", evt, 0);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_prime();
    alarms_seen = 0;
    wait_ticks(2);
    check("R11 no alarm by second tick", alarms_seen, 0);
    wait_ticks(1);
    check("R11 alarm on third tick", alarms_seen, 1);
    exp_events += 1;
    settle();
  endtask

  task automatic t_quiet();
    thresh = 16'd100;
    wait_ticks(6);
    check("R2 no alarm above threshold", alarms_seen, 0);
    check("R9 events unchanged", evt, exp_events);
  endtask

  task automatic t_equal();
    alarms_seen = 0;
    thresh = 16'd160;
    wait_ticks(6);
    check("R3 equal count not below", alarms_seen, 0);
  endtask

  task automatic t_just_below();
    alarms_seen = 0;
    thresh = 16'd161;
    wait_ticks(1);
    check("R4 one low window no alarm", alarms_seen, 0);
    wait_ticks(1);
    check("R4 alarm after two low windows", alarms_seen, 1);
    wait_ticks(4);
    check("R6 one alarm per two windows", alarms_seen, 3);
    exp_events += 3;
    check("R9 events after run", evt, exp_events);
    settle();
  endtask

  task automatic t_interrupt();
    thresh = 16'd161; wait_ticks(1);
    thresh = 16'd100; wait_ticks(1);
    thresh = 16'd161; wait_ticks(1);
    check("R5 broken run no alarm", alarms_seen, 0);
    wait_ticks(1);
    check("R5 alarm after fresh run", alarms_seen, 1);
    exp_events += 1;
    settle();
  endtask

  task automatic t_droop();
    ro_half = 0.5;
    settle();
    thresh = 16'd100;
    wait_ticks(4);
    check("R12 slow oscillator alarms", alarms_seen, 2);
    exp_events += 2;
    ro_half = 0.25;
    settle();
  endtask

  task automatic t_default();
    thresh = 16'd0;
    wait_ticks(4);
    check("R8 zero selects default", alarms_seen, 2);
    exp_events += 2;
    settle();
  endtask

  task automatic t_pulse_and_events();
    check("R7 alarm only after tick", bad_align, 0);
    check("R7 alarm one cycle wide", bad_width, 0);
    check("R9 total events", evt, exp_events);
    check("R10 saturated events", evt_sat, (exp_events > 7) ? 7 : exp_events);
  endtask

  initial begin
    t_reset();
    t_prime();
    t_quiet();
    t_equal();
    t_just_below();
    t_interrupt();
    t_droop();
    t_default();
    t_pulse_and_events();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog R1-all: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule